// File: doc/BRIEF.md
# Generation-Tagged Circular Event Queue Writer

This block is the producer half of an in-memory circular event queue. Each accepted enqueue request carries 31 bits of event data. The block forms a 32-bit queue entry from that data and a one-bit generation tag. It writes the entry with a single word write to an external memory port, then advances its write slot. The generation tag inverts every time the slot counter wraps to zero. A consumer polling the ring can therefore tell fresh entries from stale ones by comparing each entry's top bit with the generation it expects. No shared read pointer is needed.

The queue state is made of the slot counter, the generation tag and a sticky flip marker. Software can load all three at once and can read them back at any time, so a queue can be saved, moved or resumed. The queue depth comes from a 4-bit size code and equals 2^(code+10) entries. A compile-time limit caps the depth. Only one memory write is outstanding at a time.

Top module: `gen_queue_writer`

## Requirements
- R1: The stored entry holds the generation tag in bit 31 and the event data in bits 30:0.
- R2: The entry goes out in big-endian byte order. Byte lane k of `mem_wdata` (bits 8k+7:8k) carries the byte for address `mem_addr`+k, so lane 0 carries entry bits 31:24 and lane 3 carries entry bits 7:0.
- R3: `mem_addr` equals `base_addr` plus four times the slot counter taken modulo the queue depth.
- R4: After a write is acknowledged without error, the slot counter becomes (counter+1) modulo 2^(effective code+10).
- R5: When that increment wraps the counter to zero, the generation tag inverts. Otherwise the tag is unchanged.
- R6: On a wrap, the flip marker takes the new generation value. At all other times it holds its value until a state load.
- R7: If a write is acknowledged with `mem_err` high, the counter, the generation tag and the flip marker all stay unchanged.
- R8: An accepted request raises `busy` and `mem_req` from the next cycle until the cycle in which `mem_ack` is sampled. During that time `mem_addr` and `mem_wdata` stay stable, and any new `enq_valid` is ignored.
- R9: A size code above MAX_SIZE_CODE is treated as MAX_SIZE_CODE, and `size_err` is high while such a code is applied.
- R10: A pulse on `state_load` while idle writes the counter, the tag and the marker, and the new values appear on the readback ports in the next cycle. A pulse while `busy` is high is ignored.
- R11: After reset, the counter, the tag, the marker, `busy` and `mem_req` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| base_addr | input | ADDR_W | Byte address of slot 0 |
| size_code | input | 4 | Depth code, depth = 2^(code+10) |
| enq_valid | input | 1 | Enqueue request, taken when not busy |
| enq_data | input | 31 | Event payload |
| busy | output | 1 | A write is outstanding |
| mem_req | output | 1 | Memory write request |
| mem_addr | output | ADDR_W | Write byte address |
| mem_wdata | output | 32 | Write data, big-endian lanes |
| mem_ack | input | 1 | Write completion |
| mem_err | input | 1 | Write failed, qualifies mem_ack |
| state_load | input | 1 | Load queue state |
| state_load_idx | input | 10+MAX_SIZE_CODE | Slot counter value to load |
| state_load_gen | input | 1 | Generation tag value to load |
| state_load_flip | input | 1 | Flip marker value to load |
| state_idx | output | 10+MAX_SIZE_CODE | Slot counter readback |
| state_gen | output | 1 | Generation tag readback |
| state_flip | output | 1 | Flip marker readback |
| size_err | output | 1 | Size code was clamped |

## Verification
A wrong slot counter shows up on `mem_addr` at the very next accepted request. A wrong generation tag shows up in bit 31 of the next entry, and it shows in the correct byte lane only if the byte swap is also right. A wrap that is missed, or that happens early, shows up at once on `state_gen` and `state_flip`. It also appears as a tag mismatch in every entry written after it. For that reason the bench walks complete laps of the smallest ring and checks the boundary slots of the larger and clamped depths. It also checks that a failed write and any input that arrives while busy leave the readback ports unchanged.

// File: rtl/gqw_pkg.sv
package gqw_pkg;
    localparam int unsigned ENTRY_W  = 32;
    localparam int unsigned DATA_W   = 31;
    localparam int unsigned SIZE_W   = 4;
    localparam int unsigned MIN_LOG2 = 10;
    localparam int unsigned LANES    = ENTRY_W / 8;

    typedef enum logic {
        PH_IDLE = 1'b0,
        PH_WAIT = 1'b1
    } phase_e;

    typedef struct packed {
        logic              gen;
        logic [DATA_W-1:0] data;
    } entry_t;

    // Most significant byte travels on the lowest byte lane.
    function automatic logic [ENTRY_W-1:0] to_bus_order(input logic [ENTRY_W-1:0] w);
        logic [ENTRY_W-1:0] r;
        for (int k = 0; k < LANES; k++) begin
            r[8*k +: 8] = w[8*(LANES-1-k) +: 8];
        end
        return r;
    endfunction
endpackage

// File: rtl/gqw_depth.sv
module gqw_depth
    import gqw_pkg::*;
#(
    parameter int unsigned MAX_CODE = 2,
    parameter int unsigned IDX_W    = MIN_LOG2 + MAX_CODE
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [SIZE_W-1:0] size_code,
    output logic [SIZE_W-1:0] eff_code,
    output logic [IDX_W-1:0]  idx_mask,
    output logic              size_err
);
    localparam logic [SIZE_W-1:0] MAX_C = SIZE_W'(MAX_CODE);

    always_comb begin
        size_err = (size_code > MAX_C);
        eff_code = size_err ? MAX_C : size_code;
    end

    // Slot bit g is live when g < 10 + effective code.
    for (genvar g = 0; g < IDX_W; g++) begin : g_mask
        assign idx_mask[g] = ((32'(eff_code) + 32'(MIN_LOG2)) > 32'(g));
    end

    p_clamp_full_r9: assert property (@(posedge clk) disable iff (rst)
        size_err |-> ($countones(idx_mask) == IDX_W));
    p_clamp_depth_r9: assert property (@(posedge clk) disable iff (rst)
        !size_err |-> ($countones(idx_mask) == int'(size_code) + MIN_LOG2));
endmodule

// File: rtl/gqw_state.sv
module gqw_state
    import gqw_pkg::*;
#(
    parameter int unsigned IDX_W = 12
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ld_en,
    input  logic [IDX_W-1:0] ld_idx,
    input  logic             ld_gen,
    input  logic             ld_flip,
    input  logic             upd_en,
    input  logic             upd_err,
    input  logic [IDX_W-1:0] idx_mask,
    output logic [IDX_W-1:0] idx_q,
    output logic             gen_q,
    output logic             flip_q
);
    logic [IDX_W-1:0] idx_inc;
    logic             wrap;

    always_comb begin
        idx_inc = (idx_q + IDX_W'(1)) & idx_mask;
        wrap    = (idx_inc == '0);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            idx_q  <= '0;
            gen_q  <= 1'b0;
            flip_q <= 1'b0;
        end else if (ld_en) begin
            idx_q  <= ld_idx;
            gen_q  <= ld_gen;
            flip_q <= ld_flip;
        end else if (upd_en && !upd_err) begin
            idx_q <= idx_inc;
            if (wrap) begin
                gen_q  <= ~gen_q;
                flip_q <= ~gen_q;
            end
        end
    end

    p_step_r4: assert property (@(posedge clk) disable iff (rst)
        (!$stable(idx_q) && !$past(ld_en)) |->
            (idx_q == (($past(idx_q) + IDX_W'(1)) & $past(idx_mask))));
    p_gen_on_wrap_r5: assert property (@(posedge clk) disable iff (rst)
        (!$stable(gen_q) && !$past(ld_en)) |-> (idx_q == '0));
    p_flip_tracks_r6: assert property (@(posedge clk) disable iff (rst)
        (!$stable(flip_q) && !$past(ld_en)) |-> (flip_q == gen_q));
    p_err_hold_r7: assert property (@(posedge clk) disable iff (rst)
        (upd_en && upd_err && !ld_en) |=>
            ($stable(idx_q) && $stable(gen_q) && $stable(flip_q)));
endmodule

// File: rtl/gqw_port.sv
module gqw_port
    import gqw_pkg::*;
#(
    parameter int unsigned ADDR_W = 32,
    parameter int unsigned IDX_W  = 12
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               enq_valid,
    input  logic [DATA_W-1:0]  enq_data,
    input  logic [ADDR_W-1:0]  base_addr,
    input  logic [IDX_W-1:0]   idx_mask,
    input  logic [IDX_W-1:0]   idx_q,
    input  logic               gen_q,
    input  logic               mem_ack,
    input  logic               mem_err,
    output logic               busy,
    output logic               mem_req,
    output logic [ADDR_W-1:0]  mem_addr,
    output logic [ENTRY_W-1:0] mem_wdata,
    output logic               upd_en,
    output logic               upd_err,
    output logic [IDX_W-1:0]   req_mask
);
    localparam int unsigned OFF_W = IDX_W + 2;

    phase_e             phase_q;
    logic               accept;
    entry_t             entry;
    logic [ADDR_W-1:0]  offset;

    always_comb begin
        accept     = (phase_q == PH_IDLE) && enq_valid;
        entry.gen  = gen_q;
        entry.data = enq_data;
        offset     = '0;
        offset[OFF_W-1:0] = {idx_q & idx_mask, 2'b00};
        busy       = (phase_q == PH_WAIT);
        mem_req    = busy;
        upd_en     = busy && mem_ack;
        upd_err    = mem_err;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q   <= PH_IDLE;
            mem_addr  <= '0;
            mem_wdata <= '0;
            req_mask  <= '0;
        end else if (accept) begin
            phase_q   <= PH_WAIT;
            mem_addr  <= base_addr + offset;
            mem_wdata <= to_bus_order(entry);
            req_mask  <= idx_mask;
        end else if (upd_en) begin
            phase_q <= PH_IDLE;
        end
    end

    p_hold_r8: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_ack) |=>
            (mem_req && $stable(mem_addr) && $stable(mem_wdata)));
    p_release_r8: assert property (@(posedge clk) disable iff (rst)
        (mem_req && mem_ack) |=> !busy);
endmodule

// File: rtl/gen_queue_writer.sv
module gen_queue_writer
    import gqw_pkg::*;
#(
    parameter int unsigned ADDR_W        = 32,
    parameter int unsigned MAX_SIZE_CODE = 2,
    localparam int unsigned IDX_W        = MIN_LOG2 + MAX_SIZE_CODE
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [ADDR_W-1:0]  base_addr,
    input  logic [SIZE_W-1:0]  size_code,
    input  logic               enq_valid,
    input  logic [DATA_W-1:0]  enq_data,
    output logic               busy,
    output logic               mem_req,
    output logic [ADDR_W-1:0]  mem_addr,
    output logic [ENTRY_W-1:0] mem_wdata,
    input  logic               mem_ack,
    input  logic               mem_err,
    input  logic               state_load,
    input  logic [IDX_W-1:0]   state_load_idx,
    input  logic               state_load_gen,
    input  logic               state_load_flip,
    output logic [IDX_W-1:0]   state_idx,
    output logic               state_gen,
    output logic               state_flip,
    output logic               size_err
);
    logic [SIZE_W-1:0] eff_code;
    logic [IDX_W-1:0]  live_mask;
    logic [IDX_W-1:0]  req_mask;
    logic              upd_en;
    logic              upd_err;
    logic              ld_en;

    assign ld_en = state_load && !busy;

    gqw_depth #(.MAX_CODE(MAX_SIZE_CODE), .IDX_W(IDX_W)) u_depth (
        .clk(clk), .rst(rst), .size_code(size_code),
        .eff_code(eff_code), .idx_mask(live_mask), .size_err(size_err)
    );

    gqw_port #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_port (
        .clk(clk), .rst(rst), .enq_valid(enq_valid), .enq_data(enq_data),
        .base_addr(base_addr), .idx_mask(live_mask), .idx_q(state_idx),
        .gen_q(state_gen), .mem_ack(mem_ack), .mem_err(mem_err),
        .busy(busy), .mem_req(mem_req), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .upd_en(upd_en), .upd_err(upd_err),
        .req_mask(req_mask)
    );

    gqw_state #(.IDX_W(IDX_W)) u_state (
        .clk(clk), .rst(rst), .ld_en(ld_en), .ld_idx(state_load_idx),
        .ld_gen(state_load_gen), .ld_flip(state_load_flip),
        .upd_en(upd_en), .upd_err(upd_err), .idx_mask(req_mask),
        .idx_q(state_idx), .gen_q(state_gen), .flip_q(state_flip)
    );

    p_load_busy_r10: assert property (@(posedge clk) disable iff (rst)
        (state_load && busy && !mem_ack) |=>
            ($stable(state_idx) && $stable(state_gen) && $stable(state_flip)));
    p_eff_in_range_r9: assert property (@(posedge clk) disable iff (rst)
        32'(eff_code) <= MAX_SIZE_CODE);
endmodule

// File: tb/gen_queue_writer_bench.sv
module gen_queue_writer_bench;
    localparam int ADDR_W = 32;
    localparam int MAXC   = 2;
    localparam int IDX_W  = 10 + MAXC;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [ADDR_W-1:0] base_addr = 32'h8000_1000;
    logic [3:0]        size_code = 4'd0;
    logic              enq_valid = 1'b0;
    logic [30:0]       enq_data = '0;
    logic              busy, mem_req;
    logic [ADDR_W-1:0] mem_addr;
    logic [31:0]       mem_wdata;
    logic              mem_ack = 1'b0, mem_err = 1'b0;
    logic              state_load = 1'b0;
    logic [IDX_W-1:0]  state_load_idx = '0;
    logic              state_load_gen = 1'b0, state_load_flip = 1'b0;
    logic [IDX_W-1:0]  state_idx;
    logic              state_gen, state_flip, size_err;

    int errors = 0;
    int checks = 0;
    int cycles = 0;

    int          ref_idx = 0;
    logic        ref_gen = 1'b0;
    logic        ref_flip = 1'b0;

    always #2.5 clk = ~clk;

    gen_queue_writer #(.ADDR_W(ADDR_W), .MAX_SIZE_CODE(MAXC)) u_gen_queue_writer (
        .clk(clk), .rst(rst), .base_addr(base_addr), .size_code(size_code),
        .enq_valid(enq_valid), .enq_data(enq_data), .busy(busy),
        .mem_req(mem_req), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_ack(mem_ack), .mem_err(mem_err), .state_load(state_load),
        .state_load_idx(state_load_idx), .state_load_gen(state_load_gen),
        .state_load_flip(state_load_flip), .state_idx(state_idx),
        .state_gen(state_gen), .state_flip(state_flip), .size_err(size_err)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic int depth_of(input logic [3:0] code);
        int c = (int'(code) > MAXC) ? MAXC : int'(code);
        return 1 << (c + 10);
    endfunction

    task automatic chk_state(input string req);
        chk({req, " idx"},  64'(state_idx),  64'(ref_idx));
        chk({req, " gen"},  64'(state_gen),  64'(ref_gen));
        chk({req, " flip"}, 64'(state_flip), 64'(ref_flip));
    endtask

    // One enqueue; delay = idle cycles before ack; poke = drive ignored inputs while busy.
    task automatic enq(input logic [30:0] d, input int delay, input logic err, input logic poke);
        int          dep = depth_of(size_code);
        logic [31:0] e;
        logic [31:0] expw;
        logic [31:0] expa;
        @(negedge clk);
        enq_valid = 1'b1;
        enq_data  = d;
        @(negedge clk);
        enq_valid = 1'b0;
        e    = {ref_gen, d};
        expw = {e[7:0], e[15:8], e[23:16], e[31:24]};
        expa = base_addr + 32'((ref_idx % dep) * 4);
        chk("R8 busy", 64'(busy), 64'(1));
        chk("R8 req", 64'(mem_req), 64'(1));
        chk("R3 addr", 64'(mem_addr), 64'(expa));
        chk("R1 R2 data", 64'(mem_wdata), 64'(expw));
        for (int k = 0; k < delay; k++) begin
            if (poke) begin
                enq_valid       = 1'b1;
                enq_data        = ~d;
                state_load      = 1'b1;
                state_load_idx  = 12'h5A5;
                state_load_gen  = ~ref_gen;
                state_load_flip = ~ref_flip;
            end
            @(negedge clk);
            chk("R8 hold addr", 64'(mem_addr), 64'(expa));
            chk("R8 hold data", 64'(mem_wdata), 64'(expw));
        end
        enq_valid  = 1'b0;
        state_load = 1'b0;
        mem_ack    = 1'b1;
        mem_err    = err;
        @(negedge clk);
        mem_ack = 1'b0;
        mem_err = 1'b0;
        if (!err) begin
            ref_idx = (ref_idx + 1) % dep;
            if (ref_idx == 0) begin
                ref_gen  = ~ref_gen;
                ref_flip = ref_gen;
            end
        end
        chk("R8 idle after ack", 64'(busy), 64'(0));
    endtask

    task automatic load(input int idx, input logic g, input logic f);
        @(negedge clk);
        state_load      = 1'b1;
        state_load_idx  = IDX_W'(idx);
        state_load_gen  = g;
        state_load_flip = f;
        @(negedge clk);
        state_load = 1'b0;
        ref_idx  = idx;
        ref_gen  = g;
        ref_flip = f;
        chk_state("R10 load");
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 200000) begin
            errors++;
            checks++;
            $display("FAIL watchdog R8 actual=%0d expected=<200000", cycles);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R11 reset state
        chk("R11 busy", 64'(busy), 64'(0));
        chk("R11 req", 64'(mem_req), 64'(0));
        chk_state("R11");
        chk("R9 no err", 64'(size_err), 64'(0));

        // Two full laps of the smallest ring: R4, R5, R6 via state readback
        for (int i = 0; i < 2 * 1024 + 3; i++) begin
            enq(31'(i * 32'h9E37_79B1) ^ 31'h2AAA_5555, 0, 1'b0, 1'b0);
            chk_state("R4 R5 R6 sweep");
        end

        // R7: failed write leaves state alone, then the retry lands on the same slot
        enq(31'h7FFF_FFFF, 1, 1'b1, 1'b0);
        chk_state("R7 err");
        enq(31'h0000_0001, 0, 1'b0, 1'b0);
        chk_state("R7 retry");

        // R8, R10: inputs while busy are ignored
        enq(31'h1234_5678, 3, 1'b0, 1'b1);
        chk_state("R8 R10 busy poke");

        // R3: loaded counter beyond depth is taken modulo depth
        load(3000, 1'b1, 1'b0);
        enq(31'h0BAD_F00D, 0, 1'b0, 1'b0);
        chk_state("R3 R4 modulo");

        // Size code 1: wrap at 2048
        size_code = 4'd1;
        base_addr = 32'h0000_FFFC;
        load(2046, 1'b0, 1'b0);
        for (int i = 0; i < 3; i++) begin
            enq(31'(i + 32'h55), 1, 1'b0, 1'b0);
            chk_state("R4 R5 R6 code1");
        end

        // Clamped code: behaves as depth 4096, size_err raised
        size_code = 4'd9;
        @(negedge clk);
        chk("R9 err set", 64'(size_err), 64'(1));
        load(4094, 1'b1, 1'b0);
        for (int i = 0; i < 3; i++) begin
            enq(31'(32'h3C3C_0000 + i), 0, 1'b0, 1'b0);
            chk_state("R9 R5 R6 clamp");
        end
        size_code = 4'd2;
        @(negedge clk);
        chk("R9 err clear", 64'(size_err), 64'(0));

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule